// File: doc/BRIEF.md
# Interrupt Status Snapshot Controller

This block gathers a small set of fault or event sources from a peripheral domain into sticky status bits. It merges them into one interrupt line toward a processor. The line is driven only while a global enable bit is set. When the line rises, the block copies the live status into a holding data register on its own, with no software action. It shows a busy flag for a fixed interval measured in clock cycles, then reports whether the captured value stayed consistent with the live status over that interval.

Software sees three registers on a simple word-wide bus with a combinational read port and a single-cycle write strobe. An interrupt handler polls the busy bit until it drops, checks the consistency flag, then reads the data register. It acknowledges each source by writing ones to the status register.

Top module: `fault_irq_snapshot`

## Requirements
- R1: After reset, every register reads zero and irqOut is low.
- R2: A high level on srcEvent[i] during a clock edge sets status bit i (address 1). The bit stays set after the source drops.
- R3: Writing to address 1 clears each status bit whose write-data bit is one. Zero bits leave their status bit unchanged. A source held high on the same edge keeps its bit set.
- R4: irqOut is high exactly when control bit 16 (address 0) is one and at least one status bit is set. It stays low while bit 16 is zero, whatever the status holds.
- R5: In the first cycle that irqOut reads high, busy (control bit 0) still reads zero. From the next cycle, busy reads one for exactly D = CLK_MHZ*DELAY_US cycles, then reads zero.
- R6: When busy drops, the data register (address 2, status in the low bits, zeros above) holds the status value that was visible in the first cycle irqOut read high.
- R7: The consistency flag (control bit 1) reads one after a transfer if the status did not change during the busy cycles. It reads zero if the status changed at any point in them.
- R8: A rise of irqOut while busy is high neither restarts nor extends the transfer, and leaves the data register unchanged. Since the line then stays high, no later snapshot follows.
- R9: Writes to the data register, and to control bits other than 16, have no effect. Address 3 reads zero.
- R10: Control bit 16 is readable and writable, and gates the interrupt as in R4. Setting it while status is non-zero raises irqOut and starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | Fault/event source levels |
| busAddr | input | 2 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqOut | output | 1 | Combined interrupt toward the processor |

## Verification
A source level that is present at an edge shows in the status read and on irqOut at the next sampling point. Busy appears one sampling point later and lasts D points. The data and consistency flag are final at the point where busy first reads zero. Status writes show one sampling point after the write strobe. The bench drives and samples only at falling edges and waits exactly these counts before each read. It sweeps all 63 non-zero source patterns and then runs the directed cases for a status change during the busy window, a rise while busy, the enable gate, a set/clear collision and ignored writes.

// File: rtl/fault_irq_pkg.sv
`timescale 1ns/1ps
package fault_irq_pkg;
  localparam int DATA_W     = 32;
  localparam int ENABLE_BIT = 16;
  localparam int BUSY_BIT   = 0;
  localparam int OK_BIT     = 1;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_DATA   = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic capture;   // load data register from status this edge
    logic checking;  // transfer window active, compare status to snapshot
    logic busy;      // busy flag for readback
  } snap_strobe_t;
endpackage

// File: rtl/fault_irq_ctrl.sv
`timescale 1ns/1ps
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int DELAY_CYC = 2000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         irqLine,
  output snap_strobe_t strobes
);
  localparam int CNT_W = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYC - 1);

  logic             irqPrev;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             startEv;

  // a fresh rise of the interrupt line starts a transfer only when idle
  assign startEv = irqLine & ~irqPrev & ~busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev <= 1'b0;
      busyQ   <= 1'b0;
      cntQ    <= '0;
    end else begin
      irqPrev <= irqLine;
      if (startEv) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_LOAD;
      end else if (busyQ) begin
        if (cntQ == '0) busyQ <= 1'b0;
        else            cntQ  <= cntQ - CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.capture  = startEv;
    strobes.checking = busyQ;
    strobes.busy     = busyQ;
  end

  // R5: a rise seen while idle opens the window on the next edge
  assert_start_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqLine && !irqPrev && !busyQ) |=> busyQ);

  // R5: the window closes right after the counter reaches zero
  assert_window_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ == '0) |=> !busyQ);

  // R8: while busy, the counter only counts down and is never reloaded
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ != '0) |=> (busyQ && cntQ == $past(cntQ) - CNT_W'(1)));
endmodule

// File: rtl/fault_irq_dp.sv
`timescale 1ns/1ps
module fault_irq_dp
  import fault_irq_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  snap_strobe_t      strobes,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqLine
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] dataQ;
  logic               enableQ;
  logic               okQ;
  logic               wrCtrl;
  logic               wrStatus;

  assign wrCtrl   = busWrEn && (busAddr == ADDR_CTRL);
  assign wrStatus = busWrEn && (busAddr == ADDR_STATUS);

  // one sticky, write-one-to-clear cell per source; set wins over clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= srcEvent[i] | (statusQ[i] & ~(wrStatus & busWrData[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      dataQ   <= '0;
      okQ     <= 1'b0;
    end else begin
      if (wrCtrl) enableQ <= busWrData[ENABLE_BIT];
      if (strobes.capture) begin
        dataQ <= statusQ;
        okQ   <= 1'b1;
      end else if (strobes.checking && (statusQ != dataQ)) begin
        okQ <= 1'b0;
      end
    end
  end

  assign irqLine = enableQ & (|statusQ);

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_CTRL: begin
        busRdData[BUSY_BIT]   = strobes.busy;
        busRdData[OK_BIT]     = okQ;
        busRdData[ENABLE_BIT] = enableQ;
      end
      ADDR_STATUS: busRdData[NUM_SRC-1:0] = statusQ;
      ADDR_DATA:   busRdData[NUM_SRC-1:0] = dataQ;
      default:     busRdData = '0;
    endcase
  end

  // R2: a set bit survives any edge without a status write
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R6: the snapshot equals the status seen at the capture edge
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (dataQ == $past(statusQ)));

  // R8 and R9: outside a capture the data register never moves
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(dataQ));

  // R7: a mismatch inside the window leaves the flag cleared
  assert_ok_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checking && statusQ != dataQ) |=> !okQ);
endmodule

// File: rtl/fault_irq_snapshot.sv
`timescale 1ns/1ps
module fault_irq_snapshot
  import fault_irq_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int CLK_MHZ  = 200,
  parameter int DELAY_US = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [1:0]         busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               irqOut
);
  localparam int DELAY_CYC = CLK_MHZ * DELAY_US;

  snap_strobe_t strobes;
  logic         irqLine;

  fault_irq_ctrl #(.DELAY_CYC(DELAY_CYC)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .irqLine (irqLine),
    .strobes (strobes)
  );

  fault_irq_dp #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcEvent  (srcEvent),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobes   (strobes),
    .busRdData (busRdData),
    .irqLine   (irqLine)
  );

  assign irqOut = irqLine;
endmodule

// File: tb/fault_irq_snapshot_tb_top.sv
`timescale 1ns/1ps
module fault_irq_snapshot_tb_top;
  localparam int NS  = 6;
  localparam int MHZ = 1;
  localparam int US  = 10;
  localparam int D   = MHZ * US;
  localparam logic [31:0] EN = 32'h0001_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcEvent = '0;
  logic [1:0]    busAddr = 2'd0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          irqOut;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  fault_irq_snapshot #(.NUM_SRC(NS), .CLK_MHZ(MHZ), .DELAY_US(US)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #0.2;
    d = busRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic pulse(input logic [NS-1:0] p);
    srcEvent = p;
    @(negedge clk);
    srcEvent = '0;
  endtask

  // counts busy samples over D+3 falling edges; reports the first index
  task automatic watchBusy(output int cnt, output int first);
    logic [31:0] v;
    cnt = 0; first = -1;
    for (int i = 0; i < D + 3; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (v[0]) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt, first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 status", v, 0);
    rd(2'd2, v); check("R1 data", v, 0);
    check("R1 irq", {31'd0, irqOut}, 0);

    wr(2'd0, EN);
    rd(2'd0, v); check("R10 enable readback", v, EN);

    // sweep every non-zero pattern: R2 R4 R5 R6 R7 R3
    for (int p = 1; p < (1 << NS); p++) begin
      pulse(NS'(p));
      rd(2'd1, v); check("R2 status set", v, p);
      check("R4 irq high", {31'd0, irqOut}, 1);
      rd(2'd0, v); check("R5 busy low first cycle", v, EN | 32'h2 * 0 | (v & 32'h2));
      check("R5 busy bit low first cycle", {31'd0, v[0]}, 0);
      watchBusy(cnt, first);
      check("R5 busy start", first, 0);
      check("R5 busy length", cnt, D);
      rd(2'd2, v); check("R6 data", v, p);
      rd(2'd0, v); check("R7 ok stable", v, EN | 32'h2);
      wr(2'd1, p);
      rd(2'd1, v); check("R3 w1c clear", v, 0);
      check("R4 irq low after ack", {31'd0, irqOut}, 0);
    end

    // R7: status change inside the window
    pulse(6'h01);
    @(negedge clk); @(negedge clk);
    srcEvent = 6'h04;
    @(negedge clk);
    srcEvent = '0;
    repeat (D + 2) @(negedge clk);
    rd(2'd0, v); check("R7 ok dropped", v, EN);
    rd(2'd2, v); check("R6 data after change", v, 1);
    rd(2'd1, v); check("R2 both bits", v, 5);
    wr(2'd1, 32'h5);

    // R8: irq falls and rises again during busy
    pulse(6'h01);
    cnt = 0;
    for (int i = 0; i < D + 3; i++) begin
      @(negedge clk);
      busWrEn = 1'b0;
      if (i == 5) srcEvent = '0;
      rd(2'd0, v);
      if (v[0]) cnt++;
      if (i == 2) begin busAddr = 2'd1; busWrData = 32'h1; busWrEn = 1'b1; end
      if (i == 4) srcEvent = 6'h10;
    end
    busWrEn = 1'b0;
    check("R8 busy not extended", cnt, D);
    rd(2'd2, v); check("R8 data unchanged", v, 1);
    rd(2'd1, v); check("R8 new source latched", v, 32'h10);
    check("R8 irq high", {31'd0, irqOut}, 1);
    watchBusy(cnt, first);
    check("R8 no later snapshot", cnt, 0);
    wr(2'd1, 32'h10);

    // R4 R10: gate off, then enable with pending status
    wr(2'd0, 0);
    rd(2'd0, v); check("R10 disabled readback", v, 0);
    pulse(6'h08);
    check("R4 irq gated", {31'd0, irqOut}, 0);
    watchBusy(cnt, first);
    check("R4 no transfer while gated", cnt, 0);
    wr(2'd0, EN);
    check("R10 irq on enable", {31'd0, irqOut}, 1);
    watchBusy(cnt, first);
    check("R10 transfer on enable", cnt, D);
    rd(2'd2, v); check("R10 data", v, 8);

    // R9: ignored writes
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R9 data write ignored", v, 8);
    wr(2'd0, 32'hFFFE_FFFF);
    rd(2'd0, v); check("R9 ctrl other bits ignored", v, 32'h2);
    rd(2'd3, v); check("R9 spare reads zero", v, 0);
    wr(2'd1, 32'h8);

    // R3: set wins over clear, zero write keeps bit
    srcEvent = 6'h01;
    @(negedge clk);
    wr(2'd1, 32'h1);
    rd(2'd1, v); check("R3 set wins", v, 1);
    srcEvent = '0;
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R3 zero write keeps", v, 1);
    wr(2'd1, 32'h1);
    rd(2'd1, v); check("R3 clear", v, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule